// File: doc/BRIEF.md
# Dual-Mode Hysteresis Discrete Classifier

This block turns a set of digitized discrete-input levels into logical on/off sensor states. Every channel compares its unsigned input code against one of two shared threshold pairs: a ground/open pair or a supply/open pair. The channel's own mode bit picks the pair. A channel switches on above its high threshold and off below its low threshold. Between the two thresholds it keeps its previous state, so slow or noisy levels do not make it chatter.

A host loads a configuration word and a threshold word through load strobes. The configuration word holds one mode bit per channel and a test bit. When the test bit is set, each channel ignores its input and reports its mode bit, which lets the host check the path from comparator to result. Every channel stays disabled, with its output held at 0, until the configuration word has been loaded at least once after reset.

Top module: `hyst_discrete_classifier`

## Requirements
- R1: Reset (synchronous, active high) clears the configuration, the thresholds and every sensor state, and drops every channel enable. After reset, with no threshold load, every threshold reads as 0.
- R2: `chan_en` stays all zeros until the first `cfg_load`. It becomes all ones on the clock edge that takes that load, and it stays all ones until the next reset.
- R3: A channel whose enable is low drives its state to 0, whatever its input code and whatever thresholds have been loaded.
- R4: `cfg_word` bit i (counting from 0) is the mode of channel i. A 1 selects the ground/open pair and a 0 selects the supply/open pair.
- R5: Fields of `thr_word`, each with its MSB at the top: [23:18] ground/open low, [17:12] ground/open high, [11:6] supply/open low, [5:0] supply/open high.
- R6: In normal mode an enabled channel whose code is strictly greater than its extended high threshold reads 1 on the next clock edge.
- R7: In normal mode an enabled channel whose code is strictly less than its extended low threshold, and not above its high threshold, reads 0 on the next clock edge.
- R8: A code inside the band between the thresholds, including a code equal to either one, leaves the state unchanged.
- R9: When the low threshold is greater than or equal to the high threshold, a code above the high threshold sets the state to 1.
- R10: With `cfg_word` bit 8 (test) set, each enabled channel's state becomes its mode bit on the next edge, regardless of its input. After the test bit is cleared, states are held until an input crosses a threshold.
- R11: A 6-bit threshold is widened to the code width by appending zeros on the LSB side. With 8-bit codes, threshold t compares as 4*t.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sense_codes | input | NUM_CH*CODE_W | Input level codes; channel i occupies bits [i*CODE_W +: CODE_W] |
| cfg_word | input | NUM_CH+1 | Mode bits [NUM_CH-1:0] and test bit [NUM_CH] |
| cfg_load | input | 1 | Captures cfg_word and marks the block configured |
| thr_word | input | 24 | Four packed 6-bit thresholds |
| thr_load | input | 1 | Captures thr_word |
| sensor_state | output | NUM_CH | Registered logical state per channel |
| chan_en | output | NUM_CH | Per-channel enable |

## Verification
A change in an input code shows up in `sensor_state` on the first clock edge that sees it. A configuration or threshold load takes two edges to reach `sensor_state`: one to capture the word and one to classify with it. `chan_en` follows a configuration load after one edge. The bench changes inputs only on falling edges. Its reference model advances once per rising edge, using the register contents as they stood before that edge, and only then applies pending loads. Outputs are compared 2 ns after the rising edge, so each result is checked in the cycle it is due and no later.

// File: rtl/hdc_pkg.sv
package hdc_pkg;

    localparam int THR_W      = 6;
    localparam int THR_FIELDS = 4;
    localparam int THR_WORD_W = THR_W * THR_FIELDS;

    typedef logic [THR_W-1:0] thr_code_t;

    typedef enum logic {
        SENSE_SUPPLY = 1'b0,
        SENSE_GROUND = 1'b1
    } sense_mode_e;

    // Packed MSB first, so a cast from the threshold word lands each field.
    typedef struct packed {
        thr_code_t gnd_lo;
        thr_code_t gnd_hi;
        thr_code_t sup_lo;
        thr_code_t sup_hi;
    } thr_set_t;

    typedef struct packed {
        thr_code_t hi;
        thr_code_t lo;
    } thr_pair_t;

    typedef enum logic [1:0] {
        HYS_HOLD = 2'd0,
        HYS_SET  = 2'd1,
        HYS_CLR  = 2'd2
    } hys_act_e;

    function automatic thr_pair_t pick_pair(input thr_set_t t, input sense_mode_e m);
        thr_pair_t p;
        if (m == SENSE_GROUND) begin
            p.hi = t.gnd_hi;
            p.lo = t.gnd_lo;
        end else begin
            p.hi = t.sup_hi;
            p.lo = t.sup_lo;
        end
        return p;
    endfunction

endpackage

// File: rtl/hdc_cfg_regs.sv
module hdc_cfg_regs
    import hdc_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_load,
    input  logic [NUM_CH:0]       cfg_word,
    input  logic                  thr_load,
    input  logic [THR_WORD_W-1:0] thr_word,
    output logic [NUM_CH-1:0]     mode_q,
    output logic                  test_q,
    output thr_set_t              thr_q,
    output logic                  configured_q
);
    localparam int TEST_BIT = NUM_CH;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q       <= '0;
            test_q       <= 1'b0;
            configured_q <= 1'b0;
        end else if (cfg_load) begin
            mode_q       <= cfg_word[NUM_CH-1:0];
            test_q       <= cfg_word[TEST_BIT];
            configured_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '0;
        end else if (thr_load) begin
            thr_q <= thr_set_t'(thr_word);
        end
    end

endmodule

// File: rtl/hdc_channel.sv
module hdc_channel
    import hdc_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              test_en,
    input  sense_mode_e       mode,
    input  logic [CODE_W-1:0] code,
    input  thr_set_t          thr,
    output logic              state
);
    localparam int PAD = CODE_W - THR_W;

    thr_pair_t         pair;
    logic [CODE_W-1:0] hi_ext;
    logic [CODE_W-1:0] lo_ext;
    hys_act_e          act;

    assign pair = pick_pair(thr, mode);

    generate
        if (PAD > 0) begin : g_pad
            assign hi_ext = {pair.hi, {PAD{1'b0}}};
            assign lo_ext = {pair.lo, {PAD{1'b0}}};
        end else begin : g_nopad
            assign hi_ext = pair.hi[THR_W-1 -: CODE_W];
            assign lo_ext = pair.lo[THR_W-1 -: CODE_W];
        end
    endgenerate

    always_comb begin
        if (!enable) begin
            act = HYS_CLR;
        end else if (test_en) begin
            act = (mode == SENSE_GROUND) ? HYS_SET : HYS_CLR;
        end else if (code > hi_ext) begin
            act = HYS_SET;
        end else if (code < lo_ext) begin
            act = HYS_CLR;
        end else begin
            act = HYS_HOLD;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= 1'b0;
        end else begin
            case (act)
                HYS_SET: state <= 1'b1;
                HYS_CLR: state <= 1'b0;
                default: state <= state;
            endcase
        end
    end

endmodule

// File: rtl/hyst_discrete_classifier.sv
module hyst_discrete_classifier
    import hdc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH*CODE_W-1:0] sense_codes,
    input  logic [NUM_CH:0]          cfg_word,
    input  logic                     cfg_load,
    input  logic [THR_WORD_W-1:0]    thr_word,
    input  logic                     thr_load,
    output logic [NUM_CH-1:0]        sensor_state,
    output logic [NUM_CH-1:0]        chan_en
);
    logic [NUM_CH-1:0] mode_q;
    logic              test_q;
    thr_set_t          thr_q;
    logic              configured_q;

    hdc_cfg_regs #(.NUM_CH(NUM_CH)) regs_i (
        .clk          (clk),
        .rst          (rst),
        .cfg_load     (cfg_load),
        .cfg_word     (cfg_word),
        .thr_load     (thr_load),
        .thr_word     (thr_word),
        .mode_q       (mode_q),
        .test_q       (test_q),
        .thr_q        (thr_q),
        .configured_q (configured_q)
    );

    assign chan_en = {NUM_CH{configured_q}};

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            hdc_channel #(.CODE_W(CODE_W)) ch_i (
                .clk     (clk),
                .rst     (rst),
                .enable  (configured_q),
                .test_en (test_q),
                .mode    (sense_mode_e'(mode_q[i])),
                .code    (sense_codes[i*CODE_W +: CODE_W]),
                .thr     (thr_q),
                .state   (sensor_state[i])
            );
        end
    endgenerate

endmodule

// File: rtl/hdc_checker.sv
module hdc_checker
    import hdc_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CODE_W = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_CH*CODE_W-1:0] sense_codes,
    input logic [NUM_CH-1:0]        sensor_state,
    input logic [NUM_CH-1:0]        chan_en,
    input logic [NUM_CH-1:0]        mode_q,
    input logic                     test_q,
    input thr_set_t                 thr_q
);
    localparam int PAD = CODE_W - THR_W;

    logic [CODE_W-1:0] code0;
    logic [CODE_W-1:0] hi0;
    logic [CODE_W-1:0] lo0;

    assign code0 = sense_codes[CODE_W-1:0];
    assign hi0 = CODE_W'(mode_q[0] ? thr_q.gnd_hi : thr_q.sup_hi) << PAD;
    assign lo0 = CODE_W'(mode_q[0] ? thr_q.gnd_lo : thr_q.sup_lo) << PAD;

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (sensor_state == '0 && chan_en == '0));

    p_en_sticky_r2: assert property (@(posedge clk) disable iff (rst)
        chan_en[0] |=> chan_en[0]);

    p_en_uniform_r2: assert property (@(posedge clk) disable iff (rst)
        (chan_en == '0) || (&chan_en));

    p_disabled_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !chan_en[0] |=> sensor_state == '0);

    p_rise_r6: assert property (@(posedge clk) disable iff (rst)
        (chan_en[0] && !test_q && code0 > hi0) |=> sensor_state[0]);

    p_fall_r7: assert property (@(posedge clk) disable iff (rst)
        (chan_en[0] && !test_q && code0 <= hi0 && code0 < lo0) |=> !sensor_state[0]);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (chan_en[0] && !test_q && code0 <= hi0 && code0 >= lo0)
        |=> sensor_state[0] == $past(sensor_state[0]));

    p_test_force_r10: assert property (@(posedge clk) disable iff (rst)
        (chan_en[0] && test_q) |=> sensor_state == $past(mode_q));

endmodule

bind hyst_discrete_classifier hdc_checker #(
    .NUM_CH(NUM_CH),
    .CODE_W(CODE_W)
) chk_i (
    .clk          (clk),
    .rst          (rst),
    .sense_codes  (sense_codes),
    .sensor_state (sensor_state),
    .chan_en      (chan_en),
    .mode_q       (mode_q),
    .test_q       (test_q),
    .thr_q        (thr_q)
);

// File: tb/hyst_discrete_classifier_tb_top.sv
`timescale 1ns/1ps
module hyst_discrete_classifier_tb_top;
    localparam int NCH = 8;
    localparam int CW  = 8;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [NCH*CW-1:0] sense_codes = '0;
    logic [NCH:0]     cfg_word = '0;
    logic             cfg_load = 1'b0;
    logic [23:0]      thr_word = '0;
    logic             thr_load = 1'b0;
    logic [NCH-1:0]   sensor_state;
    logic [NCH-1:0]   chan_en;

    hyst_discrete_classifier #(.NUM_CH(NCH), .CODE_W(CW)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .sense_codes  (sense_codes),
        .cfg_word     (cfg_word),
        .cfg_load     (cfg_load),
        .thr_word     (thr_word),
        .thr_load     (thr_load),
        .sensor_state (sensor_state),
        .chan_en      (chan_en)
    );

    always #10 clk = ~clk;

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // reference model state
    logic [NCH:0]   m_cfg = '0;
    logic [23:0]    m_thr = '0;
    logic           m_en  = 1'b0;
    logic [NCH-1:0] m_st  = '0;

    function automatic int ext(input int t);
        return t * (1 << (CW - 6));
    endfunction

    task automatic model_edge();
        if (rst) begin
            m_st = '0;
        end else if (!m_en) begin
            m_st = '0;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                int code, hi, lo;
                code = int'(sense_codes[i*CW +: CW]);
                if (m_cfg[NCH]) begin
                    m_st[i] = m_cfg[i];
                end else begin
                    hi = m_cfg[i] ? int'(m_thr[17:12]) : int'(m_thr[5:0]);
                    lo = m_cfg[i] ? int'(m_thr[23:18]) : int'(m_thr[11:6]);
                    if (code > ext(hi))      m_st[i] = 1'b1;
                    else if (code < ext(lo)) m_st[i] = 1'b0;
                end
            end
        end
        if (rst) begin
            m_cfg = '0; m_thr = '0; m_en = 1'b0;
        end else begin
            if (cfg_load) begin m_cfg = cfg_word; m_en = 1'b1; end
            if (thr_load) m_thr = thr_word;
        end
    endtask

    task automatic tick(input bit do_chk, input string tag);
        logic [NCH-1:0] exp_en;
        @(posedge clk);
        model_edge();
        #2;
        exp_en = m_en ? '1 : '0;
        if (do_chk) begin
            n_vec++;
            if (sensor_state !== m_st || chan_en !== exp_en) begin
                n_fail++;
                $display("FAIL %s: state=%b en=%b expected state=%b en=%b",
                         tag, sensor_state, chan_en, m_st, exp_en);
            end
        end
        @(negedge clk);
    endtask

    task automatic set_all(input int v);
        for (int i = 0; i < NCH; i++) sense_codes[i*CW +: CW] = CW'(v);
    endtask

    task automatic load_cfg(input logic [NCH:0] w, input string tag);
        cfg_word = w; cfg_load = 1'b1;
        tick(1, tag);
        cfg_load = 1'b0;
    endtask

    task automatic load_thr(input logic [23:0] w, input string tag);
        thr_word = w; thr_load = 1'b1;
        tick(1, tag);
        thr_load = 1'b0;
    endtask

    function automatic logic [23:0] thr_pack(input int gl, gh, sl, sh);
        return {6'(gl), 6'(gh), 6'(sl), 6'(sh)};
    endfunction

    task automatic sweep(input int pat, input string tag);
        for (int k = 0; k < 256; k++) begin
            for (int i = 0; i < NCH; i++) begin
                int v;
                case (pat)
                    0: v = (k + i * 29) % 256;
                    1: v = (255 - k + i * 17) % 256;
                    default: v = (k < 128) ? (k * 2 + i * 7) % 256 : ((255 - k) * 2 + i * 7) % 256;
                endcase
                sense_codes[i*CW +: CW] = CW'(v);
            end
            tick(1, tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        tick(1, "R1");
        tick(1, "R1");
        rst = 1'b0;
        // R2 / R3: no configuration yet, outputs stay low
        load_thr(thr_pack(8, 16, 4, 12), "R3");
        set_all(255);
        tick(1, "R3");
        tick(1, "R2");
        set_all(0);
        tick(1, "R3");
        // R2: first configuration load enables all channels
        load_cfg(9'b0_1010_0101, "R2");
        // R4 / R6 / R7 / R8 with mixed modes
        load_thr(thr_pack(16, 32, 8, 48), "R5");
        sweep(0, "R6");
        sweep(1, "R7");
        sweep(2, "R8");
        load_cfg(9'b0_0101_1010, "R4");
        sweep(0, "R4");
        // R5: distinct fields
        load_thr(thr_pack(5, 40, 20, 60), "R5");
        sweep(2, "R5");
        // R11: exact boundary (ground high 32 -> 128)
        load_cfg(9'b0_1111_1111, "R11");
        load_thr(thr_pack(16, 32, 0, 63), "R11");
        set_all(0);   tick(1, "R11");
        set_all(128); tick(1, "R11");
        set_all(129); tick(1, "R11");
        set_all(64);  tick(1, "R11");
        set_all(63);  tick(1, "R11");
        // R9: low >= high
        load_thr(thr_pack(48, 16, 40, 40), "R9");
        load_cfg(9'b0_0011_1100, "R9");
        sweep(0, "R9");
        set_all(80); tick(1, "R9");
        // R10: test mode
        load_cfg(9'b1_0110_1001, "R10");
        set_all(255); tick(1, "R10");
        set_all(0);   tick(1, "R10");
        load_cfg(9'b1_1001_0110, "R10");
        tick(1, "R10");
        load_thr(thr_pack(0, 63, 0, 63), "R10");
        load_cfg(9'b0_1001_0110, "R10");
        set_all(100); tick(1, "R10");
        tick(1, "R10");
        // R1: mid-run reset clears registers
        rst = 1'b1;
        tick(1, "R1");
        rst = 1'b0;
        tick(1, "R1");
        load_cfg(9'b0_1111_1111, "R1");
        set_all(5); tick(1, "R1");
        set_all(0); tick(1, "R1");
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule